// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block performs 32-bit integer multiplication and division for a processor core. Its results do not go to the general register file. They land in a dedicated pair of result registers, HI and LO, and the operation decides what each half holds. A multiply leaves the 64-bit product split across the pair, with the upper half in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI.

A one-cycle start pulse launches an operation. The operation code and both operands are sampled on that pulse. The unit then iterates for 32 cycles, using shift-add for multiply and restoring subtraction for divide. It holds a busy flag for the whole run and updates HI and LO together in the same edge that raises a one-cycle done pulse. When the unit is idle, each register can also be loaded directly through its own write port. Signed operations reduce both operands to magnitudes first and correct the signs of the results at the end.

Top module: `muldiv_hilo`

## Requirements
- R1: Operation code 2'b00 (unsigned multiply) treats both operands as unsigned and leaves product bits 31..0 in `lo` and bits 63..32 in `hi`.
- R2: Operation code 2'b01 (signed multiply) treats both operands as two's complement and leaves the two's-complement 64-bit product split the same way, upper half in `hi` and lower half in `lo`.
- R3: Operation code 2'b10 (unsigned divide) leaves the unsigned quotient in `lo` and the remainder in `hi`.
- R4: Operation code 2'b11 (signed divide) truncates the quotient toward zero and gives the remainder the sign of the dividend. The case 0x80000000 divided by 0xFFFFFFFF gives `lo` = 0x80000000 and `hi` = 0.
- R5: A divide with a zero divisor still runs for the full 32 cycles and raises `done`, but leaves `hi` and `lo` unchanged.
- R6: A start accepted at one clock edge drives `busy` high for exactly 32 cycles, starting with the next cycle. In the first cycle after that run, `busy` is low, `done` is high for that single cycle, and the new `hi`/`lo` values are already visible. A start pulse in that same cycle is accepted.
- R7: A start pulse while `busy` is high is ignored. The running operation completes with its original operands and at its original time.
- R8: While the unit is idle, `hi_we` loads `hi_wd` into `hi` and `lo_we` loads `lo_wd` into `lo`, and neither write changes the other register. Both writes are ignored while `busy` is high.
- R9: While reset is asserted (`rst_n` low), `hi`, `lo`, `busy` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches an operation when the unit is idle |
| op | input | 2 | Bit 1 selects divide, bit 0 selects signed |
| a | input | 32 | Multiplicand or dividend |
| b | input | 32 | Multiplier or divisor |
| hi_we | input | 1 | Write enable for HI |
| hi_wd | input | 32 | Write data for HI |
| lo_we | input | 1 | Write enable for LO |
| lo_wd | input | 32 | Write data for LO |
| busy | output | 1 | High while an operation is running |
| done | output | 1 | One-cycle pulse when the results are written |
| hi | output | 32 | HI result register |
| lo | output | 32 | LO result register |

## Verification
The assertions check the timing on every cycle: a run is exactly 32 busy cycles, `done` is a single pulse that follows a run, `busy` only rises after a start, and HI and LO stay put while the unit is idle and their write enables are low. The arithmetic can only be shown by the bench's scenarios. These cover the unsigned extremes, sign combinations for both signed operations, the most negative dividend over -1, a zero divisor, a start issued mid-run, writes issued mid-run, and a start in the done cycle.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         hi_we,
  input  logic [W-1:0] hi_wd,
  input  logic         lo_we,
  input  logic [W-1:0] lo_wd,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int CW = $clog2(W);

  logic [2*W-1:0] acc;
  logic [W-1:0]   dv;
  logic [CW-1:0]  cnt;
  logic           is_div, neg_q, neg_r, dz;

  wire a_neg = op[0] & a[W-1];
  wire b_neg = op[0] & b[W-1];
  wire [W-1:0] a_mag = a_neg ? -a : a;
  wire [W-1:0] b_mag = b_neg ? -b : b;

  wire [W:0]     msum  = {1'b0, acc[2*W-1:W]} + (acc[0] ? {1'b0, dv} : {(W+1){1'b0}});
  wire [2*W-1:0] mnext = {msum, acc[W-1:1]};

  wire [W:0]     dsh   = {acc[2*W-1:W], acc[W-1]};
  wire [W+1:0]   ddiff = {1'b0, dsh} - {2'b00, dv};
  wire [2*W-1:0] dnext = ddiff[W+1] ? {dsh[W-1:0], acc[W-2:0], 1'b0}
                                    : {ddiff[W-1:0], acc[W-2:0], 1'b1};

  wire [2*W-1:0] nxt  = is_div ? dnext : mnext;
  wire [2*W-1:0] pfix = neg_q ? -nxt : nxt;
  wire [W-1:0]   qfix = neg_q ? -nxt[W-1:0] : nxt[W-1:0];
  wire [W-1:0]   rfix = neg_r ? -nxt[2*W-1:W] : nxt[2*W-1:W];
  wire           last = (cnt == CW'(W-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      hi     <= '0;
      lo     <= '0;
      acc    <= '0;
      dv     <= '0;
      cnt    <= '0;
      is_div <= 1'b0;
      neg_q  <= 1'b0;
      neg_r  <= 1'b0;
      dz     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc <= nxt;
        cnt <= cnt + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (!is_div) begin
            hi <= pfix[2*W-1:W];
            lo <= pfix[W-1:0];
          end else if (!dz) begin
            hi <= rfix;
            lo <= qfix;
          end
        end
      end else begin
        if (hi_we) hi <= hi_wd;
        if (lo_we) lo <= lo_wd;
        if (start) begin
          busy   <= 1'b1;
          cnt    <= '0;
          is_div <= op[1];
          neg_q  <= a_neg ^ b_neg;
          neg_r  <= a_neg;
          dz     <= (b == '0);
          acc    <= {{W{1'b0}}, op[1] ? a_mag : b_mag};
          dv     <= op[1] ? b_mag : a_mag;
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         hi_we,
  input logic         lo_we,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  int run;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) run <= 0;
    else run <= run + 1;
  end

  assert_run_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(run) == W-1));

  assert_run_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < W));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_hi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !hi_we) |=> $stable(hi));

  assert_lo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !lo_we) |=> $stable(lo));
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .hi_we(hi_we), .lo_we(lo_we), .hi(hi), .lo(lo)
);

// File: tb/sim_muldiv_hilo.sv
`timescale 1ns/100ps
module sim_muldiv_hilo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [31:0] a = '0, b = '0, hi_wd = '0, lo_wd = '0;
  logic hi_we = 1'b0, lo_we = 1'b0;
  logic busy, done;
  logic [31:0] hi, lo;

  int checks = 0;
  int failures = 0;
  string cur_req = "R9";
  bit finished = 0;

  always #2.5 clk = ~clk;

  muldiv_hilo u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
    .hi_we(hi_we), .hi_wd(hi_wd), .lo_we(lo_we), .lo_wd(lo_wd),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  logic m_busy, m_done, m_dz;
  logic [31:0] m_hi, m_lo, p_hi, p_lo;
  int m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_hi = 0; m_lo = 0; m_cnt = 0; m_dz = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 32) begin
          m_busy = 0;
          m_done = 1;
          if (!m_dz) begin m_hi = p_hi; m_lo = p_lo; end
        end
      end else begin
        if (hi_we) m_hi = hi_wd;
        if (lo_we) m_lo = lo_wd;
        if (start) begin
          logic [63:0] up;
          longint sa, sb, q, r;
          m_busy = 1; m_cnt = 0; m_dz = 0;
          sa = longint'($signed(a));
          sb = longint'($signed(b));
          case (op)
            2'b00: begin up = {32'b0, a} * {32'b0, b}; p_hi = up[63:32]; p_lo = up[31:0]; end
            2'b01: begin up = 64'(sa * sb); p_hi = up[63:32]; p_lo = up[31:0]; end
            2'b10: begin
              m_dz = (b == 0);
              if (!m_dz) begin p_lo = a / b; p_hi = a % b; end
            end
            default: begin
              m_dz = (b == 0);
              if (!m_dz) begin q = sa / sb; r = sa % sb; p_lo = q[31:0]; p_hi = r[31:0]; end
            end
          endcase
        end
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("busy", {31'b0, busy}, {31'b0, m_busy});
      chk("done", {31'b0, done}, {31'b0, m_done});
      chk("hi", hi, m_hi);
      chk("lo", lo, m_lo);
    end
  end

  task automatic go(string req, logic [1:0] o, logic [31:0] x, logic [31:0] y);
    @(negedge clk); #1;
    cur_req = req; start = 1; op = o; a = x; b = y;
    @(negedge clk); #1;
    start = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic finish_up();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;

    go("R1", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF); wait_done();
    go("R1", 2'b00, 32'h1234_5678, 32'h9ABC_DEF0); wait_done();
    go("R2", 2'b01, 32'hFFFF_FFFD, 32'd7); wait_done();
    go("R2", 2'b01, 32'h8000_0000, 32'h8000_0000); wait_done();
    go("R2", 2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF); wait_done();
    go("R3", 2'b10, 32'd100, 32'd7); wait_done();
    go("R3", 2'b10, 32'hFFFF_FFFF, 32'd1); wait_done();
    go("R3", 2'b10, 32'd5, 32'hFFFF_FFFF); wait_done();
    go("R4", 2'b11, 32'hFFFF_FFF9, 32'd2); wait_done();
    go("R4", 2'b11, 32'd7, 32'hFFFF_FFFE); wait_done();
    go("R4", 2'b11, 32'h8000_0000, 32'hFFFF_FFFF); wait_done();

    @(negedge clk); #1;
    cur_req = "R8"; hi_we = 1; hi_wd = 32'hAAAA_5555;
    @(negedge clk); #1;
    hi_we = 0; lo_we = 1; lo_wd = 32'h1357_9BDF;
    @(negedge clk); #1;
    lo_we = 0;

    go("R5", 2'b10, 32'd5, 32'd0); wait_done();
    go("R5", 2'b11, 32'hFFFF_FF00, 32'd0); wait_done();

    go("R7", 2'b00, 32'd6, 32'd9);
    repeat (5) @(negedge clk);
    #1 start = 1; op = 2'b11; a = 32'd1000; b = 32'd3;
    @(negedge clk); #1 start = 0;
    cur_req = "R8"; hi_we = 1; hi_wd = 32'hDEAD_BEEF; lo_we = 1; lo_wd = 32'hCAFE_F00D;
    @(negedge clk); #1 hi_we = 0; lo_we = 0;
    wait_done();

    #1 cur_req = "R6"; start = 1; op = 2'b10; a = 32'd77; b = 32'd10;
    @(negedge clk); #1 start = 0;
    wait_done();

    repeat (3) @(negedge clk);
    #1 cur_req = "R9"; rst_n = 0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1;
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule